// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects error and condition events from each port of a four-port cell interface. Each port has a control register and a status register on a small address/read/write bus. Each status event sets a sticky bit. The bit stays set until software reads that port's status register. All ports share one active-low interrupt output, and any port can pull it low.

Every port has a global pin-enable bit and an errors-only bit. When errors-only is set, only received cell errors reach the pin. Neither bit affects how the status bits latch. Each port also checks each transmit byte for odd parity when its check bit is set. It tracks the level of a signal-quality input with a two-state machine, SIG_BAD and SIG_GOOD. The transition GO_GOOD moves from SIG_BAD to SIG_GOOD when the input is high, and GO_BAD moves back when the input is low. Either transition sets the signal-change status bit.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: After reset every control bit is 0, every sticky status bit is 0 and `irq_n` is 1.
- R2: Port p has its control register at address 0x10*p and its status register at 0x10*p+1. Control bit 0 is the pin enable, bit 1 is errors-only and bit 4 is the parity check enable. All other control bits, and every other offset, read as 0. Read data is valid in the same cycle as `bus_rd`.
- R3: The sticky status bits are bit 1 (header error), bit 2 (short cell), bit 3 (transmit parity error), bit 4 (signal change), bit 5 (symbol error) and bit 6 (FIFO overflow). Bit 7 reads 0. An event pulse sets its bit at the next clock edge, and the bit holds until it is read.
- R4: A read of a status register returns its current value and clears the sticky bits at that edge. An event that arrives in the same cycle as the read still leaves its bit set.
- R5: Status bit 0 reads 1 when the tracked signal is good, one cycle after the input changes. It is not sticky and a read does not clear it.
- R6: The signal-change bit sets on a bad-to-good transition and on a good-to-bad transition.
- R7: With control bit 4 set, a transmit byte whose data and parity bit hold an even count of ones sets the transmit parity error bit. With control bit 4 clear, no parity error is recorded.
- R8: With control bit 0 clear, the port never pulls `irq_n` low, but its status bits still latch.
- R9: With control bits 0 and 1 both set, only the header error and short cell bits can pull `irq_n` low.
- R10: `irq_n` is the AND of the per-port requests. It goes low in the cycle after an enabled event and stays low until every pending enabled port has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| sig_good | input | 4 | Per-port signal-quality level, 1 = good |
| hec_ev | input | 4 | Per-port header error pulse |
| short_ev | input | 4 | Per-port short cell pulse |
| sym_ev | input | 4 | Per-port undefined-symbol pulse |
| ovf_ev | input | 4 | Per-port receive FIFO overflow pulse |
| tx_valid | input | 4 | Per-port transmit byte strobe |
| tx_data | input | 32 | Per-port transmit bytes, port p in bits 8p+7..8p |
| tx_par | input | 4 | Per-port transmit parity bit |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The bench builds the block with four ports and 8-bit transmit bytes. With these values the whole register map is in range: the port index fills the upper address bits, so every port and every offset can be reached. Four independent requesters make the AND-combined pin observable while some ports are pending and others are cleared. Errors-only, parity and the signal-tracking machine each run on their own port, so one scenario's sticky bits never mask another's.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Control register bit positions
    localparam int CTL_PIN_EN  = 0;
    localparam int CTL_ERR_ONLY = 1;
    localparam int CTL_PAR_CHK = 4;
    localparam logic [7:0] CTL_MASK = 8'h13;

    // Status register bit positions
    localparam int ST_GOOD  = 0;
    localparam int ST_HEC   = 1;
    localparam int ST_SHORT = 2;
    localparam int ST_TXPAR = 3;
    localparam int ST_CHG   = 4;
    localparam int ST_SYM   = 5;
    localparam int ST_OVF   = 6;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_STAT = 4'h1;

    typedef enum logic {
        SIG_BAD  = 1'b0,
        SIG_GOOD = 1'b1
    } sig_state_t;
endpackage

// File: rtl/odd_parity_chk.sv
module odd_parity_chk #(
    parameter int DATA_W = 8
) (
    input  logic              chk_en,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              err
);
    // Odd parity: data plus parity bit must hold an odd count of ones
    always_comb begin
        err = chk_en && valid && !(^{data, par});
    end
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              stat_rd,
    input  logic              sig_good,
    input  logic              hec_ev,
    input  logic              short_ev,
    input  logic              sym_ev,
    input  logic              ovf_ev,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_par,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        stat_q,
    output logic              req_n
);
    sig_state_t state_q, state_d;
    logic       chg_ev;
    logic       par_err;
    logic [6:1] sticky_q, sticky_d, ev_vec;

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata & CTL_MASK;
    end

    // Signal-quality tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SIG_BAD;
        else        state_q <= state_d;
    end

    // Signal-quality tracker: next state and change event
    always_comb begin
        state_d = state_q;
        chg_ev  = 1'b0;
        unique case (state_q)
            SIG_BAD: if (sig_good) begin    // GO_GOOD
                state_d = SIG_GOOD;
                chg_ev  = 1'b1;
            end
            SIG_GOOD: if (!sig_good) begin  // GO_BAD
                state_d = SIG_BAD;
                chg_ev  = 1'b1;
            end
        endcase
    end

    odd_parity_chk #(.DATA_W(DATA_W)) u_par (
        .chk_en (ctrl_q[CTL_PAR_CHK]),
        .valid  (tx_valid),
        .data   (tx_data),
        .par    (tx_par),
        .err    (par_err)
    );

    // Sticky status: clear on read, same-cycle event wins
    always_comb begin
        ev_vec           = '0;
        ev_vec[ST_HEC]   = hec_ev;
        ev_vec[ST_SHORT] = short_ev;
        ev_vec[ST_TXPAR] = par_err;
        ev_vec[ST_CHG]   = chg_ev;
        ev_vec[ST_SYM]   = sym_ev;
        ev_vec[ST_OVF]   = ovf_ev;
        sticky_d = (stat_rd ? '0 : sticky_q) | ev_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    always_comb begin
        stat_q          = {1'b0, sticky_q, 1'b0};
        stat_q[ST_GOOD] = (state_q == SIG_GOOD);
    end

    // Per-port request
    always_comb begin
        if (!ctrl_q[CTL_PIN_EN])
            req_n = 1'b1;
        else if (ctrl_q[CTL_ERR_ONLY])
            req_n = !(sticky_q[ST_HEC] || sticky_q[ST_SHORT]);
        else
            req_n = !(|sticky_q);
    end

    // R3
    hec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hec_ev |=> sticky_q[ST_HEC]);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q[ST_OVF] && !stat_rd) |=> sticky_q[ST_OVF]);

    // R6
    sig_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> sticky_q[ST_CHG]);

    // R7
    tx_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && ctrl_q[CTL_PAR_CHK] && ((^{tx_data, tx_par}) == 1'b0))
        |=> sticky_q[ST_TXPAR]);

    // R9
    err_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_PIN_EN] && ctrl_q[CTL_ERR_ONLY] &&
         !sticky_q[ST_HEC] && !sticky_q[ST_SHORT]) |-> req_n);
endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl
    import irq_pkg::*;
#(
    parameter  int NPORTS = 4,
    parameter  int DATA_W = 8,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int ADDR_W = PORT_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [7:0]               bus_wdata,
    input  logic                     bus_rd,
    output logic [7:0]               bus_rdata,
    input  logic [NPORTS-1:0]        sig_good,
    input  logic [NPORTS-1:0]        hec_ev,
    input  logic [NPORTS-1:0]        short_ev,
    input  logic [NPORTS-1:0]        sym_ev,
    input  logic [NPORTS-1:0]        ovf_ev,
    input  logic [NPORTS-1:0]        tx_valid,
    input  logic [NPORTS*DATA_W-1:0] tx_data,
    input  logic [NPORTS-1:0]        tx_par,
    output logic                     irq_n
);
    logic [PORT_W-1:0] sel_port;
    logic [3:0]        sel_off;
    logic [7:0]        ctrl_v [NPORTS];
    logic [7:0]        stat_v [NPORTS];
    logic [NPORTS-1:0] req_n_v;
    logic [NPORTS-1:0] pin_en_v;

    assign sel_port = bus_addr[ADDR_W-1:4];
    assign sel_off  = bus_addr[3:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit;
        assign hit = (sel_port == PORT_W'(p));

        port_irq_unit #(.DATA_W(DATA_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (bus_wr && hit && (sel_off == OFF_CTRL)),
            .ctrl_wdata (bus_wdata),
            .stat_rd    (bus_rd && hit && (sel_off == OFF_STAT)),
            .sig_good   (sig_good[p]),
            .hec_ev     (hec_ev[p]),
            .short_ev   (short_ev[p]),
            .sym_ev     (sym_ev[p]),
            .ovf_ev     (ovf_ev[p]),
            .tx_valid   (tx_valid[p]),
            .tx_data    (tx_data[p*DATA_W +: DATA_W]),
            .tx_par     (tx_par[p]),
            .ctrl_q     (ctrl_v[p]),
            .stat_q     (stat_v[p]),
            .req_n      (req_n_v[p])
        );
        assign pin_en_v[p] = ctrl_v[p][CTL_PIN_EN];
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel_port == PORT_W'(p)) begin
                if (sel_off == OFF_CTRL)      bus_rdata = ctrl_v[p];
                else if (sel_off == OFF_STAT) bus_rdata = stat_v[p];
            end
        end
    end

    assign irq_n = &req_n_v;

    // R8
    pin_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pin_en_v) |-> irq_n);

    // R1
    reset_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_n);
endmodule

// File: tb/sim_sticky_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sticky_irq_ctrl;
    localparam int NP = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] sig_good = '0;
    logic [NP-1:0] hec_ev = '0;
    logic [NP-1:0] short_ev = '0;
    logic [NP-1:0] sym_ev = '0;
    logic [NP-1:0] ovf_ev = '0;
    logic [NP-1:0] tx_valid = '0;
    logic [NP*DW-1:0] tx_data = '0;
    logic [NP-1:0] tx_par = '0;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sticky_irq_ctrl #(.NPORTS(NP), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sig_good(sig_good), .hec_ev(hec_ev), .short_ev(short_ev),
        .sym_ev(sym_ev), .ovf_ev(ovf_ev), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_par(tx_par), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_tx(input int p, input logic [7:0] d, input logic par);
        @(negedge clk);
        tx_valid[p] = 1'b1; tx_data[p*DW +: DW] = d; tx_par[p] = par;
        @(negedge clk);
        tx_valid[p] = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        for (int p = 0; p < NP; p++) begin
            rd_reg(6'(p*16), v);
            check("R1 ctrl reset", v, 8'h00);
            rd_reg(6'(p*16 + 1), v);
            check("R1 status reset", v, 8'h00);
        end
    endtask

    task automatic test_regmap();
        logic [7:0] v;
        wr_reg(6'h20, 8'hFF);
        rd_reg(6'h20, v);
        check("R2 ctrl writable bits", v, 8'h13);
        rd_reg(6'h00, v);
        check("R2 other port ctrl untouched", v, 8'h00);
        rd_reg(6'h25, v);
        check("R2 unused offset", v, 8'h00);
        wr_reg(6'h20, 8'h00);
    endtask

    task automatic test_mask_and_clear();
        logic [7:0] v;
        @(negedge clk); hec_ev[0] = 1'b1;
        @(negedge clk); hec_ev[0] = 1'b0;
        #1 check("R8 pin stays high when disabled", {7'b0, irq_n}, 8'h01);
        rd_reg(6'h01, v);
        check("R3 R8 header error latched", v, 8'h02);
        rd_reg(6'h01, v);
        check("R4 cleared by read", v, 8'h00);
        @(negedge clk); sym_ev[0] = 1'b1; short_ev[0] = 1'b1;
        @(negedge clk); sym_ev[0] = 1'b0; short_ev[0] = 1'b0;
        repeat (3) @(negedge clk);
        rd_reg(6'h01, v);
        check("R3 symbol and short latched", v, 8'h24);
    endtask

    task automatic test_same_cycle();
        logic [7:0] v;
        @(negedge clk);
        bus_addr = 6'h01; bus_rd = 1'b1; hec_ev[0] = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; hec_ev[0] = 1'b0;
        check("R4 read value before event", v, 8'h00);
        rd_reg(6'h01, v);
        check("R4 same-cycle event survives", v, 8'h02);
    endtask

    task automatic test_pin_enabled();
        logic [7:0] v;
        wr_reg(6'h10, 8'h01);
        #1 check("R10 no pending, pin high", {7'b0, irq_n}, 8'h01);
        @(negedge clk); ovf_ev[1] = 1'b1;
        @(negedge clk); ovf_ev[1] = 1'b0;
        #1 check("R10 pin low after event", {7'b0, irq_n}, 8'h00);
        rd_reg(6'h11, v);
        check("R3 fifo overflow bit", v, 8'h40);
        #1 check("R10 pin high after read", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic test_and_ports();
        logic [7:0] v;
        wr_reg(6'h00, 8'h01);
        @(negedge clk); ovf_ev[0] = 1'b1; ovf_ev[1] = 1'b1;
        @(negedge clk); ovf_ev[0] = 1'b0; ovf_ev[1] = 1'b0;
        rd_reg(6'h01, v);
        #1 check("R10 other port still pulls low", {7'b0, irq_n}, 8'h00);
        rd_reg(6'h11, v);
        #1 check("R10 pin released after both read", {7'b0, irq_n}, 8'h01);
        wr_reg(6'h00, 8'h00);
        wr_reg(6'h10, 8'h00);
    endtask

    task automatic test_err_only();
        logic [7:0] v;
        wr_reg(6'h20, 8'h03);
        @(negedge clk); sym_ev[2] = 1'b1;
        @(negedge clk); sym_ev[2] = 1'b0;
        #1 check("R9 symbol error blocked", {7'b0, irq_n}, 8'h01);
        rd_reg(6'h21, v);
        check("R9 symbol status still latched", v, 8'h20);
        @(negedge clk); short_ev[2] = 1'b1;
        @(negedge clk); short_ev[2] = 1'b0;
        #1 check("R9 short cell asserts pin", {7'b0, irq_n}, 8'h00);
        rd_reg(6'h21, v);
        check("R9 short cell status", v, 8'h04);
        #1 check("R9 pin released", {7'b0, irq_n}, 8'h01);
        wr_reg(6'h20, 8'h00);
    endtask

    task automatic test_parity();
        logic [7:0] v;
        send_tx(3, 8'h03, 1'b0);
        rd_reg(6'h31, v);
        check("R7 check disabled ignores bad byte", v, 8'h00);
        wr_reg(6'h30, 8'h10);
        send_tx(3, 8'h01, 1'b0);
        rd_reg(6'h31, v);
        check("R7 odd count accepted", v, 8'h00);
        send_tx(3, 8'h03, 1'b0);
        rd_reg(6'h31, v);
        check("R7 even count flagged", v, 8'h08);
        send_tx(3, 8'h03, 1'b1);
        rd_reg(6'h31, v);
        check("R7 corrected parity accepted", v, 8'h00);
        wr_reg(6'h30, 8'h00);
    endtask

    task automatic test_signal();
        logic [7:0] v;
        @(negedge clk); sig_good[0] = 1'b1;
        @(negedge clk);
        rd_reg(6'h01, v);
        check("R5 R6 rising change", v, 8'h11);
        rd_reg(6'h01, v);
        check("R5 good bit not cleared", v, 8'h01);
        @(negedge clk); sig_good[0] = 1'b0;
        @(negedge clk);
        rd_reg(6'h01, v);
        check("R6 falling change", v, 8'h10);
        rd_reg(6'h01, v);
        check("R5 bad level", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regmap();
        test_mask_and_clear();
        test_same_cycle();
        test_pin_enabled();
        test_and_ports();
        test_err_only();
        test_parity();
        test_signal();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule